// File: doc/BRIEF.md
# Register Access Workaround Sequencer

The sequencer accepts one register operation at a time from a host port and expands it into a series of 64-bit transactions on a downstream register bus. It supports four operations: read, write, set-bits and clear-bits. Set-bits and clear-bits run as a read followed by a write of the merged word.

When the workaround strap is high and the target offset lies below 0x45000, each real access is wrapped in dummy reads. One dummy read goes before the access, and its address depends on the target offset. After the access comes a dummy read of 0x38, but only for target 0x100, and then a dummy read of 0xB050. The data that dummy reads return is thrown away. When the strap is low, or the offset is outside the window, only the real access is issued.

The host waits on `req_ready` while a sequence runs. It collects the result when `rsp_done` pulses.

Top module: `regwrap_seq`

## Requirements
- R1: With `wa_enable` low at acceptance, a read or write issues exactly one bus transaction, to the target offset. A set-bits or clear-bits issues exactly two: a read of the target, then a write of the target.
- R2: With `wa_enable` high, a target offset of 0x45000 or above gets no dummy transactions. A target below 0x45000 is wrapped.
- R3: Each wrapped access begins with a dummy read whose address depends on the target: 0xC0 for targets 0x0 and 0x80, 0x28 for targets 0x148 and 0x200, and 0x158 for every other in-window target.
- R4: After a wrapped access to target 0x100, a dummy read of 0x38 follows the real access. No other target gets the 0x38 read.
- R5: Every wrapped access ends with a dummy read of 0xB050. For target 0x100 this read comes after the 0x38 read.
- R6: All dummy transactions are reads (`bus_write` = 0). Their returned data never reaches `rsp_data` or the merged write word. A bus write is always followed by a read or by the end of the operation.
- R7: A set-bits operation (`req_op` = 2'b10) does a full wrapped read of the target, then a full wrapped write of the returned word OR `req_data`.
- R8: A clear-bits operation (`req_op` = 2'b11) does the same as set-bits, but the word written is the returned word AND NOT `req_data`.
- R9: `req_ready` is high only when no operation is in progress. It falls on the cycle after a request is accepted and stays low until the cycle of `rsp_done`. While it is high, `bus_valid` is low.
- R10: `bus_valid`, `bus_addr`, `bus_write` and `bus_wdata` stay stable until `bus_ack`. The next transaction starts only in the cycle after the acknowledge.
- R11: Operation codes are 2'b00 read, 2'b01 write, 2'b10 set-bits and 2'b11 clear-bits. `rsp_done` pulses for exactly one cycle per operation. `rsp_data` carries the target's read data for a read, and the word written for every other operation.
- R12: After a synchronous reset, `req_ready` is 1 and `bus_valid` and `rsp_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wa_enable | input | 1 | Workaround strap, sampled when a request is accepted |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Sequencer idle and able to accept a request |
| req_op | input | 2 | Operation code |
| req_offset | input | ADDR_W | Target register offset |
| req_data | input | DATA_W | Write data, or the bit mask for set/clear |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_data | output | DATA_W | Read data, or the written word |
| bus_valid | output | 1 | Downstream transaction request |
| bus_write | output | 1 | Transaction is a write |
| bus_addr | output | ADDR_W | Transaction offset |
| bus_wdata | output | DATA_W | Write data |
| bus_ack | input | 1 | Downstream acknowledge |
| bus_rdata | input | DATA_W | Read data, valid with `bus_ack` |

## Verification
The assertions check the bus and host handshakes on every cycle. This covers holding a transaction until it is acknowledged, keeping the bus quiet while the sequencer is ready, dropping ready after acceptance, the single-cycle done pulse, and the rule that no write follows another write. Only the bench scenarios can show the order and addresses of the dummy reads for each target class, the window boundary at 0x45000, the effect of the strap, and the read-modify-write arithmetic. The bench checks these by comparing the full logged transaction list and the device model's contents against expected values it computes itself.

// File: rtl/regwrap_pkg.sv
package regwrap_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLR   = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_REAL,
    ST_POST_A,
    ST_POST_B
  } step_e;

  localparam logic [31:0] WIN_LIMIT  = 32'h0004_5000;
  localparam logic [31:0] PRE_LOW    = 32'h0000_00C0;
  localparam logic [31:0] PRE_MID    = 32'h0000_0028;
  localparam logic [31:0] PRE_OTHER  = 32'h0000_0158;
  localparam logic [31:0] POST_A_OFF = 32'h0000_0038;
  localparam logic [31:0] POST_B_OFF = 32'h0000_B050;
  localparam logic [31:0] TRIG_A     = 32'h0000_0100;

endpackage

// File: rtl/regwrap_route.sv
module regwrap_route
  import regwrap_pkg::*;
#(
  parameter int ADDR_W = 27
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] off,
  output logic              in_win,
  output logic              need_post_a,
  output logic [ADDR_W-1:0] pre_addr
);
  logic [31:0] off_ext;

  always_comb begin
    off_ext     = 32'(off);
    in_win      = en && (off_ext < WIN_LIMIT);
    need_post_a = in_win && (off_ext == TRIG_A);
    if (off_ext == 32'h0 || off_ext == 32'h80)
      pre_addr = ADDR_W'(PRE_LOW);
    else if (off_ext == 32'h148 || off_ext == 32'h200)
      pre_addr = ADDR_W'(PRE_MID);
    else
      pre_addr = ADDR_W'(PRE_OTHER);
  end
endmodule

// File: rtl/regwrap_merge.sv
module regwrap_merge
  import regwrap_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  op_e               op,
  input  logic [DATA_W-1:0] rd,
  input  logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] wr
);
  always_comb begin
    case (op)
      OP_SET:  wr = rd | mask;
      OP_CLR:  wr = rd & ~mask;
      default: wr = mask;
    endcase
  end
endmodule

// File: rtl/regwrap_seq.sv
module regwrap_seq
  import regwrap_pkg::*;
#(
  parameter int ADDR_W = 27,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wa_enable,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [DATA_W-1:0] req_data,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_data,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata
);
  step_e             state, nstate;
  op_e               op_q;
  logic              en_q, phase_wr;
  logic [ADDR_W-1:0] off_q;
  logic [DATA_W-1:0] data_q, rd_q, wr_q;

  logic              idle, accept, step_done, is_rmw;
  logic              cap_now, restart, finish, wr_next;
  logic              r_en, in_win, need_a;
  logic [ADDR_W-1:0] r_off, pre_addr;
  logic [DATA_W-1:0] merged, rd_now, wr_src;
  step_e             first;

  assign idle      = (state == ST_IDLE);
  assign req_ready = idle;
  assign accept    = req_valid && idle;
  assign step_done = bus_valid && bus_ack;
  assign is_rmw    = (op_q == OP_SET) || (op_q == OP_CLR);
  assign r_off     = idle ? req_offset : off_q;
  assign r_en      = idle ? wa_enable : en_q;

  regwrap_route #(.ADDR_W(ADDR_W)) u_route (
    .en          (r_en),
    .off         (r_off),
    .in_win      (in_win),
    .need_post_a (need_a),
    .pre_addr    (pre_addr)
  );

  regwrap_merge #(.DATA_W(DATA_W)) u_merge (
    .op   (op_q),
    .rd   (bus_rdata),
    .mask (data_q),
    .wr   (merged)
  );

  assign cap_now = step_done && (state == ST_REAL) && !bus_write;
  assign rd_now  = cap_now ? bus_rdata : rd_q;
  assign wr_src  = cap_now ? merged : wr_q;
  assign first   = in_win ? ST_PRE : ST_REAL;

  function automatic logic [ADDR_W-1:0] addr_for(input step_e s,
                                                 input logic [ADDR_W-1:0] pre,
                                                 input logic [ADDR_W-1:0] tgt);
    case (s)
      ST_PRE:    return pre;
      ST_POST_A: return ADDR_W'(POST_A_OFF);
      ST_POST_B: return ADDR_W'(POST_B_OFF);
      default:   return tgt;
    endcase
  endfunction

  // Next step after the current transaction is acknowledged
  always_comb begin
    nstate  = ST_IDLE;
    restart = 1'b0;
    case (state)
      ST_PRE:    nstate = ST_REAL;
      ST_REAL:   nstate = need_a ? ST_POST_A : (in_win ? ST_POST_B : ST_IDLE);
      ST_POST_A: nstate = ST_POST_B;
      default:   nstate = ST_IDLE;
    endcase
    if (nstate == ST_IDLE && is_rmw && !phase_wr) begin
      restart = 1'b1;
      nstate  = first;
    end
    finish  = (nstate == ST_IDLE);
    wr_next = (nstate == ST_REAL) && ((op_q == OP_WRITE) || phase_wr || restart);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      op_q      <= OP_READ;
      en_q      <= 1'b0;
      phase_wr  <= 1'b0;
      off_q     <= '0;
      data_q    <= '0;
      rd_q      <= '0;
      wr_q      <= '0;
      rsp_done  <= 1'b0;
      rsp_data  <= '0;
      bus_valid <= 1'b0;
      bus_write <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      rsp_done <= 1'b0;
      if (accept) begin
        op_q      <= op_e'(req_op);
        off_q     <= req_offset;
        data_q    <= req_data;
        en_q      <= wa_enable;
        phase_wr  <= 1'b0;
        state     <= first;
        bus_valid <= 1'b1;
        bus_addr  <= addr_for(first, pre_addr, req_offset);
        bus_write <= (first == ST_REAL) && (op_e'(req_op) == OP_WRITE);
        bus_wdata <= ((first == ST_REAL) && (op_e'(req_op) == OP_WRITE)) ? req_data : '0;
      end else if (step_done) begin
        if (cap_now) begin
          rd_q <= bus_rdata;
          wr_q <= merged;
        end
        if (finish) begin
          state     <= ST_IDLE;
          bus_valid <= 1'b0;
          bus_write <= 1'b0;
          bus_wdata <= '0;
          rsp_done  <= 1'b1;
          rsp_data  <= (op_q == OP_READ) ? rd_now :
                       (op_q == OP_WRITE) ? data_q : wr_src;
        end else begin
          state     <= nstate;
          phase_wr  <= phase_wr | restart;
          bus_addr  <= addr_for(nstate, pre_addr, off_q);
          bus_write <= wr_next;
          bus_wdata <= wr_next ? ((op_q == OP_WRITE) ? data_q : wr_src) : '0;
        end
      end
    end
  end
endmodule

// File: rtl/regwrap_seq_chk.sv
module regwrap_seq_chk #(
  parameter int ADDR_W = 27,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_done,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_ack
);
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
    bus_valid && !bus_ack |=> bus_valid && $stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata)); // R10
  AST_QUIET_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !bus_valid); // R9
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done); // R11
  AST_DONE_READY: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> req_ready); // R9
  AST_WRITE_ALONE: assert property (@(posedge clk) disable iff (rst)
    bus_valid && bus_write && bus_ack |=> !(bus_valid && bus_write)); // R6
endmodule

bind regwrap_seq regwrap_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_done(rsp_done), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack)
);

// File: tb/test_regwrap_seq.sv
`timescale 1ns/1ps
module test_regwrap_seq;
  localparam int AW = 27;
  localparam int DW = 64;

  logic clk = 1'b0, rst = 1'b1;
  logic wa_enable = 1'b0, req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [AW-1:0] req_offset = '0;
  logic [DW-1:0] req_data = '0;
  logic req_ready, rsp_done, bus_valid, bus_write;
  logic [DW-1:0] rsp_data, bus_wdata;
  logic [AW-1:0] bus_addr;
  logic bus_ack = 1'b0;
  logic [DW-1:0] bus_rdata = '0;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  regwrap_seq #(.ADDR_W(AW), .DATA_W(DW)) i_regwrap_seq (
    .clk(clk), .rst(rst), .wa_enable(wa_enable), .req_valid(req_valid),
    .req_ready(req_ready), .req_op(req_op), .req_offset(req_offset),
    .req_data(req_data), .rsp_done(rsp_done), .rsp_data(rsp_data),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  logic [DW-1:0] mem [int unsigned];
  int unsigned log_a[$], exp_a[$];
  bit log_w[$], exp_w[$];
  int hold_err = 0;

  function automatic logic [DW-1:0] init_word(int unsigned a);
    return 64'hA5C3_0000_0000_0000 ^ {a, ~a};
  endfunction

  function automatic logic [DW-1:0] mem_rd(int unsigned a);
    return mem.exists(a) ? mem[a] : init_word(a);
  endfunction

  task automatic check(string tag, bit ok, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Downstream device model with random acknowledge latency
  initial begin
    int wait_c = 0;
    bit pend = 0;
    logic [AW-1:0] pend_a = '0;
    forever begin
      @(negedge clk);
      if (pend && !(bus_valid && bus_addr == pend_a)) hold_err++; // R10
      pend = 0;
      if (bus_ack) begin
        bus_ack = 1'b0;
        wait_c = $urandom % 3;
      end else if (bus_valid) begin
        if (wait_c == 0) begin
          bus_ack = 1'b1;
          log_a.push_back(32'(bus_addr));
          log_w.push_back(bus_write);
          if (bus_write) begin
            mem[32'(bus_addr)] = bus_wdata;
            bus_rdata = '0;
          end else bus_rdata = mem_rd(32'(bus_addr));
        end else begin
          wait_c--;
          pend = 1;
          pend_a = bus_addr;
        end
      end
    end
  end

  task automatic push_access(int unsigned off, bit wr, bit en);
    bit win = en && off < 32'h45000;
    if (win) begin
      if (off == 0 || off == 32'h80) exp_a.push_back(32'hC0);
      else if (off == 32'h148 || off == 32'h200) exp_a.push_back(32'h28);
      else exp_a.push_back(32'h158);
      exp_w.push_back(0);
    end
    exp_a.push_back(off); exp_w.push_back(wr);
    if (win && off == 32'h100) begin exp_a.push_back(32'h38); exp_w.push_back(0); end
    if (win) begin exp_a.push_back(32'hB050); exp_w.push_back(0); end
  endtask

  task automatic run_op(string tag, bit en, logic [1:0] op, int unsigned off, logic [DW-1:0] d);
    logic [DW-1:0] old = mem_rd(off), exp_rsp;
    bit seq_ok;
    int dones = 0, rdy_err = 0;
    exp_a.delete(); exp_w.delete(); log_a.delete(); log_w.delete();
    case (op)
      2'd0: begin push_access(off, 0, en); exp_rsp = old; end
      2'd1: begin push_access(off, 1, en); exp_rsp = d; end
      2'd2: begin push_access(off, 0, en); push_access(off, 1, en); exp_rsp = old | d; end
      default: begin push_access(off, 0, en); push_access(off, 1, en); exp_rsp = old & ~d; end
    endcase
    @(negedge clk);
    wa_enable = en; req_op = op; req_offset = AW'(off); req_data = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    wa_enable = ~en; // strap is sampled only at acceptance
    while (dones == 0) begin
      if (rsp_done) dones++;
      else if (req_ready) rdy_err++;
      if (dones == 0) @(negedge clk);
    end
    @(negedge clk);
    if (rsp_done) dones++;
    seq_ok = (log_a.size() == exp_a.size());
    if (seq_ok) foreach (exp_a[i]) if (log_a[i] != exp_a[i] || log_w[i] != exp_w[i]) seq_ok = 0;
    check({tag, " sequence"}, seq_ok, 64'(log_a.size()), 64'(exp_a.size()));
    check({tag, " R11 rsp_data"}, rsp_data === exp_rsp, rsp_data, exp_rsp);
    check({tag, " R11 done pulse"}, dones == 1, 64'(dones), 64'd1);
    check({tag, " R9 ready low while busy"}, rdy_err == 0, 64'(rdy_err), 64'd0);
    if (op != 2'd0) check({tag, " written word"}, mem_rd(off) === exp_rsp, mem_rd(off), exp_rsp);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R12 reset state", req_ready === 1'b1 && bus_valid === 1'b0 && rsp_done === 1'b0,
          {61'd0, req_ready, bus_valid, rsp_done}, 64'h4);
    run_op("R1 strap low read", 0, 2'd0, 32'h100, '0);
    run_op("R1 strap low write", 0, 2'd1, 32'h80, 64'h1234);
    run_op("R1 strap low set", 0, 2'd2, 32'h200, 64'hF0);
    run_op("R2 at limit", 1, 2'd0, 32'h45000, '0);
    run_op("R2 below limit", 1, 2'd0, 32'h44FF8, '0);
    run_op("R3 target 0", 1, 2'd0, 32'h0, '0);
    run_op("R3 target 80", 1, 2'd1, 32'h80, 64'hDEAD_BEEF);
    run_op("R3 target 148", 1, 2'd0, 32'h148, '0);
    run_op("R3 target 200", 1, 2'd1, 32'h200, 64'h55);
    run_op("R4 R5 target 100 write", 1, 2'd1, 32'h100, 64'hCAFE);
    run_op("R4 target 38", 1, 2'd0, 32'h38, '0);
    run_op("R6 dummy data discarded", 1, 2'd0, 32'hC0, '0);
    run_op("R7 set bits", 1, 2'd2, 32'h80, 64'hFF00_0000_0000_000F);
    run_op("R8 clear bits", 1, 2'd3, 32'h100, 64'h0F0F_0F0F_0F0F_0F0F);
    run_op("R8 clear strap low", 0, 2'd3, 32'h148, 64'hFFFF);
    for (int n = 0; n < 60; n++) begin
      int unsigned off;
      case ($urandom % 8)
        0: off = 32'h0;
        1: off = 32'h100;
        2: off = 32'h148;
        3: off = 32'h45000;
        4: off = 32'h44FF8;
        5: off = ($urandom % 32'h45000) & ~32'h7;
        6: off = 32'h45000 + (($urandom % 32'h10000) & ~32'h7);
        default: off = 32'h200;
      endcase
      run_op("R3 R5 R7 random", 1'($urandom), 2'($urandom), off, {$urandom, $urandom});
    end
    check("R10 hold until ack", hold_err == 0, 64'(hold_err), 64'd0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule